// File: doc/BRIEF.md
# Exact-Count Read Collector

This block sits on the target side of a bridge and serves one read request at a time. A request names a starting dword address, a length, a source channel and a mode bit. In the speculative mode the block launches a single read burst on its master port and keeps whatever the target delivers before it disconnects, even if that is fewer dwords than asked for. In the exact mode the block keeps launching bursts until the full count has arrived. Each follow-on burst starts at the dword after the last one received and asks only for the remainder.

Collected dwords are held in an internal buffer and offered on a ready/valid return stream. Retained data stays until the requester has drained it. If no word is consumed for a master-timeout period, the data is thrown away and the block becomes free again. The period is 2^15 or 2^10 clock cycles, chosen by an input. Eight source channels each hold an exact-mode enable and a 10-bit amount. The request picks the channel, and a request that asks for exact mode on a disabled channel is served as a speculative read.

The controller has four states. IDLE waits for a request. ISSUE drives a one-cycle burst launch. COLLECT stores arriving dwords. HOLD offers the data to the requester. The transitions are ACCEPT (IDLE to ISSUE on a request), LAUNCH (ISSUE to COLLECT, always), REISSUE (COLLECT to ISSUE when an exact burst ends short), COMPLETE (COLLECT to HOLD when the count is reached, or when a speculative burst ends with data), EMPTY (COLLECT to IDLE when a speculative burst ends with no data), DRAINED (HOLD to IDLE on the last consumed word) and EXPIRE (HOLD to IDLE on timeout).

Top module: `rd_collect_engine`

## Requirements
- R1: During and after reset the block is in IDLE: `req_ready`=1, while `rd_start`, `ret_valid` and `ret_discard` are 0.
- R2: Each of the 8 channels holds an enable and a 10-bit amount, written through `cfg_we`/`cfg_chan`/`cfg_en`/`cfg_amount`; all reset to 0. A request reads the entry selected by `req_chan`. A write in the same cycle as an accepted request affects only later requests.
- R3: A requested length (the channel amount in exact mode, `req_dwords` in speculative mode) of 0 is served as 1 dword, and a length above 512 is served as 512 dwords.
- R4: A request is accepted when `req_valid` and `req_ready` are both 1. `rd_start` pulses for one cycle in the following cycle. The first burst uses `rd_addr`=`req_addr` and `rd_len`=the full length. In speculative mode (`req_exact`=0) exactly one burst is issued.
- R5: In exact mode (`req_exact`=1 with the channel enabled), a burst that ends short is followed one cycle later by a new `rd_start` pulse. The new burst uses `rd_addr` = first address + dwords received so far and `rd_len` = dwords still missing. This repeats until the full length is held.
- R6: A request with `req_exact`=1 whose channel enable is 0 behaves exactly like a speculative request of `req_dwords`.
- R7: Retained dwords appear on `ret_data` in arrival order, with `ret_last`=1 on the final one. `ret_valid`, `ret_data` and `ret_last` stay steady while `ret_ready` is 0. After the last word is taken, `req_ready` returns in the next cycle.
- R8: A burst ends on `rd_disc`, and a dword presented with `rd_disc` in the same cycle is kept. A burst also ends, without any disconnect, in the cycle its requested count is reached. `rd_dvalid` and `rd_disc` have no effect outside a burst.
- R9: A speculative burst that ends with no dword received returns the block to IDLE without raising `ret_valid`.
- R10: If nothing is consumed during HOLD, `ret_valid` stays 1 for exactly 2^15 cycles (`short_timeout`=0) or 2^10 cycles (`short_timeout`=1). `ret_discard` is 1 in the last of those cycles, and the block is IDLE in the next cycle with the data dropped.
- R11: Every consumed word restarts the timeout count. A word consumed in the cycle the timeout would expire is delivered, and no discard occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Channel table write strobe |
| cfg_chan | input | 3 | Channel table entry to write |
| cfg_en | input | 1 | Exact-mode enable for the written entry |
| cfg_amount | input | 10 | Exact-mode dword amount for the written entry |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 30 | First dword address |
| req_dwords | input | 10 | Length used in speculative mode |
| req_exact | input | 1 | 1 asks for exact mode |
| req_chan | input | 3 | Source channel selecting a table entry |
| rd_start | output | 1 | One-cycle burst launch |
| rd_addr | output | 30 | Burst start dword address |
| rd_len | output | 10 | Burst dword count |
| rd_dvalid | input | 1 | Target delivers a dword this cycle |
| rd_data | input | 32 | Delivered dword |
| rd_disc | input | 1 | Target ends the burst |
| ret_valid | output | 1 | Retained dword offered |
| ret_ready | input | 1 | Requester takes the offered dword |
| ret_data | output | 32 | Offered dword |
| ret_last | output | 1 | Offered dword is the final one |
| ret_discard | output | 1 | Retained data dropped by timeout this cycle |
| short_timeout | input | 1 | 1 selects the 2^10-cycle timeout, 0 the 2^15-cycle one |

## Verification
In HOLD, a consumed word and the timeout can land on the same cycle, and consumption must win. The bench holds `ret_ready` low for exactly 1023 cycles after `ret_valid` rises under the short timeout, then raises it on the 1024th cycle, which is the expiring one. It expects that word to be delivered with `ret_discard` low. It then expects a full new 1024-cycle wait before the discard. A second pairing is a target disconnect on the same cycle as the final dword of a burst. The bench provokes it with exact bursts that end early, and judges it by the dword count and by the address of the follow-on burst.

// File: rtl/rce_pkg.sv
package rce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_COLLECT,
        ST_HOLD
    } rce_state_e;

endpackage

// File: rtl/rce_chan_table.sv
module rce_chan_table #(
    parameter int CHANNELS = 8,
    parameter int AMT_W    = 10,
    parameter int CH_W     = $clog2(CHANNELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic             wr_enable,
    input  logic [AMT_W-1:0] wr_amt,
    input  logic [CH_W-1:0]  rd_chan,
    output logic             rd_enable,
    output logic [AMT_W-1:0] rd_amt
);

    logic             en_vec  [CHANNELS];
    logic [AMT_W-1:0] amt_vec [CHANNELS];

    for (genvar g = 0; g < CHANNELS; g++) begin : g_entry
        logic             en_q;
        logic [AMT_W-1:0] amt_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q  <= 1'b0;
                amt_q <= '0;
            end else if (wr_en && (wr_chan == CH_W'(g))) begin
                en_q  <= wr_enable;
                amt_q <= wr_amt;
            end
        end

        assign en_vec[g]  = en_q;
        assign amt_vec[g] = amt_q;
    end

    assign rd_enable = en_vec[rd_chan];
    assign rd_amt    = amt_vec[rd_chan];

endmodule

// File: rtl/rce_dword_buf.sv
module rce_dword_buf #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/rce_hold_timer.sv
module rce_hold_timer #(
    parameter int LONG_LOG2  = 15,
    parameter int SHORT_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic short_sel,
    output logic expire
);

    localparam int             TO_W       = LONG_LOG2;
    localparam logic [TO_W-1:0] LONG_LAST  = {TO_W{1'b1}};
    localparam logic [TO_W-1:0] SHORT_LAST = TO_W'((1 << SHORT_LOG2) - 1);

    logic [TO_W-1:0] tick_q;

    // Idle cycles spent in HOLD since entry or since the last consumed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!run || restart || expire) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign expire = run && (tick_q == (short_sel ? SHORT_LAST : LONG_LAST));

endmodule

// File: rtl/rd_collect_engine.sv
module rd_collect_engine #(
    parameter int CHANNELS   = 8,
    parameter int AMT_W      = 10,
    parameter int MAX_DW     = 512,
    parameter int ADDR_W     = 30,
    parameter int DATA_W     = 32,
    parameter int LONG_LOG2  = 15,
    parameter int SHORT_LOG2 = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [$clog2(CHANNELS)-1:0] cfg_chan,
    input  logic                        cfg_en,
    input  logic [AMT_W-1:0]            cfg_amount,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [AMT_W-1:0]            req_dwords,
    input  logic                        req_exact,
    input  logic [$clog2(CHANNELS)-1:0] req_chan,
    output logic                        rd_start,
    output logic [ADDR_W-1:0]           rd_addr,
    output logic [AMT_W-1:0]            rd_len,
    input  logic                        rd_dvalid,
    input  logic [DATA_W-1:0]           rd_data,
    input  logic                        rd_disc,
    output logic                        ret_valid,
    input  logic                        ret_ready,
    output logic [DATA_W-1:0]           ret_data,
    output logic                        ret_last,
    output logic                        ret_discard,
    input  logic                        short_timeout
);

    import rce_pkg::*;

    localparam int CH_W  = $clog2(CHANNELS);
    localparam int IDX_W = $clog2(MAX_DW);

    rce_state_e       state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [AMT_W-1:0]  total_q, got_q, rd_q;
    logic              exact_q;

    logic              sel_en;
    logic [AMT_W-1:0]  sel_amt;
    logic              accept, req_is_exact, word_in, reached, burst_end;
    logic              take, final_out, expire, drop;
    logic [AMT_W-1:0]  req_total, got_inc;

    function automatic logic [AMT_W-1:0] clamp_len(input logic [AMT_W-1:0] v);
        if (v == '0)                 return AMT_W'(1);
        if (v > AMT_W'(MAX_DW))      return AMT_W'(MAX_DW);
        return v;
    endfunction

    rce_chan_table #(.CHANNELS(CHANNELS), .AMT_W(AMT_W), .CH_W(CH_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_chan   (cfg_chan),
        .wr_enable (cfg_en),
        .wr_amt    (cfg_amount),
        .rd_chan   (req_chan),
        .rd_enable (sel_en),
        .rd_amt    (sel_amt)
    );

    rce_dword_buf #(.DEPTH(MAX_DW), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .wr_en   (word_in),
        .wr_idx  (got_q[IDX_W-1:0]),
        .wr_data (rd_data),
        .rd_idx  (rd_q[IDX_W-1:0]),
        .rd_data (ret_data)
    );

    rce_hold_timer #(.LONG_LOG2(LONG_LOG2), .SHORT_LOG2(SHORT_LOG2)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_HOLD),
        .restart   (take),
        .short_sel (short_timeout),
        .expire    (expire)
    );

    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign req_is_exact = req_exact && sel_en;
    assign req_total    = req_is_exact ? clamp_len(sel_amt) : clamp_len(req_dwords);
    assign word_in      = (state_q == ST_COLLECT) && rd_dvalid;
    assign got_inc      = got_q + {{(AMT_W-1){1'b0}}, word_in};
    assign reached      = (got_inc == total_q);
    assign burst_end    = (state_q == ST_COLLECT) && (rd_disc || reached);
    assign take         = (state_q == ST_HOLD) && ret_ready;
    assign final_out    = ((rd_q + 1'b1) == got_q);
    assign drop         = expire && !take;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_ISSUE;            // ACCEPT
            ST_ISSUE:   state_d = ST_COLLECT;                      // LAUNCH
            ST_COLLECT: begin
                if (burst_end) begin
                    if (reached)            state_d = ST_HOLD;     // COMPLETE
                    else if (exact_q)       state_d = ST_ISSUE;    // REISSUE
                    else if (got_inc == '0) state_d = ST_IDLE;     // EMPTY
                    else                    state_d = ST_HOLD;     // COMPLETE
                end
            end
            ST_HOLD: begin
                if ((take && final_out) || drop) state_d = ST_IDLE; // DRAINED / EXPIRE
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // Request context and progress counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            total_q <= '0;
            got_q   <= '0;
            rd_q    <= '0;
            exact_q <= 1'b0;
        end else begin
            if (accept) begin
                base_q  <= req_addr;
                total_q <= req_total;
                exact_q <= req_is_exact;
                got_q   <= '0;
                rd_q    <= '0;
            end
            if (word_in) got_q <= got_inc;
            if (take)    rd_q  <= rd_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rd_start    = (state_q == ST_ISSUE);
        rd_addr     = base_q + ADDR_W'(got_q);
        rd_len      = total_q - got_q;
        ret_valid   = (state_q == ST_HOLD);
        ret_last    = (state_q == ST_HOLD) && final_out;
        ret_discard = (state_q == ST_HOLD) && drop;
    end

endmodule

// File: rtl/rce_checker.sv
module rce_checker #(
    parameter int AMT_W  = 10,
    parameter int DATA_W = 32,
    parameter int MAX_DW = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_start,
    input logic [AMT_W-1:0]  rd_len,
    input logic              ret_valid,
    input logic              ret_ready,
    input logic [DATA_W-1:0] ret_data,
    input logic              ret_last,
    input logic              ret_discard
);

    AST_ACCEPT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rd_start);                                   // R4

    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);                                                // R5

    AST_LAUNCH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> !ret_valid && !req_ready);                                 // R4

    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> (rd_len != '0) && (rd_len <= AMT_W'(MAX_DW)));             // R3

    AST_RET_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && !ret_ready && !ret_discard |=>
            ret_valid && $stable(ret_data) && $stable(ret_last));               // R7

    AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && ret_ready && ret_last |=> req_ready);                      // R7

    AST_DISCARD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        ret_discard |=> !ret_valid && req_ready);                               // R10

    AST_TAKE_BEATS_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        ret_discard |-> ret_valid && !ret_ready);                               // R11

endmodule

bind rd_collect_engine rce_checker #(
    .AMT_W  (AMT_W),
    .DATA_W (DATA_W),
    .MAX_DW (MAX_DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rd_start    (rd_start),
    .rd_len      (rd_len),
    .ret_valid   (ret_valid),
    .ret_ready   (ret_ready),
    .ret_data    (ret_data),
    .ret_last    (ret_last),
    .ret_discard (ret_discard)
);

// File: tb/rd_collect_engine_tb.sv
module rd_collect_engine_tb;

    localparam int AMT_W  = 10;
    localparam int ADDR_W = 30;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0, cfg_en = 1'b0;
    logic [2:0]        cfg_chan = '0;
    logic [AMT_W-1:0]  cfg_amount = '0;
    logic              req_valid = 1'b0, req_exact = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [AMT_W-1:0]  req_dwords = '0;
    logic [2:0]        req_chan = '0;
    logic              rd_start, rd_dvalid = 1'b0, rd_disc = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic [AMT_W-1:0]  rd_len;
    logic [DATA_W-1:0] rd_data = '0;
    logic              ret_valid, ret_ready, ret_last, ret_discard;
    logic [DATA_W-1:0] ret_data;
    logic              short_timeout = 1'b0;

    logic [1:0]  rmode = 2'd0;     // 0 always ready, 1 pseudo-random, 3 manual
    logic        man_rdy = 1'b0, auto_rdy = 1'b1;
    logic [15:0] lfsr = 16'hACE1;
    assign ret_ready = (rmode == 2'd3) ? man_rdy : auto_rdy;

    always #5 clk = ~clk;

    rd_collect_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_en(cfg_en), .cfg_amount(cfg_amount),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_dwords(req_dwords), .req_exact(req_exact), .req_chan(req_chan),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_dvalid(rd_dvalid), .rd_data(rd_data), .rd_disc(rd_disc),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_data(ret_data),
        .ret_last(ret_last), .ret_discard(ret_discard), .short_timeout(short_timeout)
    );

    int compared = 0, mismatched = 0;
    bit finished = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(logic [29:0] a);
        return 32'hC0DE_0000 ^ ({2'b00, a} * 32'h0000_9E37);
    endfunction

    function automatic int clampv(int v);
        if (v == 0) return 1;
        if (v > 512) return 512;
        return v;
    endfunction

    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        auto_rdy <= (rmode == 2'd1) ? lfsr[3] : 1'b1;
    end

    // Scripted target: gives min(t_give, len) dwords per burst
    int          t_give = 0;
    bit          t_gap = 0, t_sep = 0;
    bit          t_act = 0, t_pend = 0;
    logic [29:0] t_addr;
    int          t_len, t_left, t_idx, t_phase;

    always @(negedge clk) begin
        rd_dvalid = 1'b0;
        rd_disc   = 1'b0;
        rd_data   = '0;
        if (t_act) begin
            if (t_pend) begin
                rd_disc = 1'b1; t_act = 0; t_pend = 0;
            end else if (t_left == 0) begin
                rd_disc = 1'b1; t_act = 0;
            end else begin
                t_phase++;
                if (!(t_gap && (t_phase % 2 == 0))) begin
                    rd_dvalid = 1'b1;
                    rd_data   = pat(30'(t_addr + t_idx));
                    t_idx++;
                    t_left--;
                    if (t_left == 0) begin
                        if (t_give >= t_len) t_act = 0;
                        else if (t_sep)      t_pend = 1;
                        else begin rd_disc = 1'b1; t_act = 0; end
                    end
                end
            end
        end
        if (rst_n && rd_start) begin
            t_act = 1; t_pend = 0; t_addr = rd_addr; t_len = int'(rd_len);
            t_left = (t_give < t_len) ? t_give : t_len;
            t_idx = 0; t_phase = 0;
        end
    end

    // Behavioural reference model, compared every cycle
    int          m_st = 0;          // 0 idle, 1 launch, 2 gather, 3 offer
    logic [29:0] m_base;
    int          m_total, m_got, m_rd, m_timer;
    bit          m_exact;
    logic [31:0] mq[$];
    bit          m_en [8];
    int          m_amt [8];
    int          n_start = 0, n_take = 0, n_disc = 0, first_len = -1;

    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            int lim;
            lim = short_timeout ? 1024 : 32768;
            check("R1", "req_ready", req_ready, m_st == 0);
            check("R5", "rd_start", rd_start, m_st == 1);
            if (m_st == 1 && rd_start) begin
                check("R5", "rd_addr", rd_addr, 30'(m_base + m_got));
                check("R5", "rd_len", rd_len, m_total - m_got);
            end
            check("R7", "ret_valid", ret_valid, m_st == 3);
            if (m_st == 3 && ret_valid) begin
                check("R7", "ret_data", ret_data, mq[m_rd]);
                check("R7", "ret_last", ret_last, m_rd == m_got - 1);
            end
            check("R10", "ret_discard", ret_discard,
                  (m_st == 3) && !ret_ready && (m_timer == lim - 1));
            if (rd_start) begin
                if (first_len < 0) first_len = int'(rd_len);
                n_start++;
            end
            if (ret_valid && ret_ready) n_take++;
            if (ret_discard) n_disc++;

            case (m_st)
                0: if (req_valid) begin
                    m_exact = req_exact && m_en[req_chan];
                    m_total = clampv(m_exact ? m_amt[req_chan] : int'(req_dwords));
                    m_base = req_addr; m_got = 0; m_rd = 0; mq.delete();
                    m_st = 1;
                end
                1: m_st = 2;
                2: begin
                    if (rd_dvalid) begin
                        mq.push_back(pat(30'(m_base + m_got)));
                        m_got++;
                    end
                    if (rd_disc || m_got == m_total) begin
                        if (m_got == m_total) m_st = 3;
                        else if (m_exact)     m_st = 1;
                        else if (m_got == 0)  m_st = 0;
                        else                  m_st = 3;
                        m_timer = 0; m_rd = 0;
                    end
                end
                default: begin
                    if (ret_ready) begin
                        m_rd++; m_timer = 0;
                        if (m_rd == m_got) m_st = 0;
                    end else if (m_timer == lim - 1) m_st = 0;
                    else m_timer++;
                end
            endcase
            if (cfg_we) begin
                m_en[cfg_chan]  = cfg_en;
                m_amt[cfg_chan] = int'(cfg_amount);
            end
        end
    end

    task automatic cfg(int ch, bit en, int amt);
        @(negedge clk);
        cfg_we = 1; cfg_chan = 3'(ch); cfg_en = en; cfg_amount = AMT_W'(amt);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!req_ready);
    endtask

    task automatic issue(bit ex, int ch, int addr, int dw, int give, bit gap, bit sep);
        @(negedge clk);
        n_start = 0; n_take = 0; n_disc = 0; first_len = -1;
        t_give = give; t_gap = gap; t_sep = sep;
        req_valid = 1; req_exact = ex; req_chan = 3'(ch);
        req_addr = ADDR_W'(addr); req_dwords = AMT_W'(dw);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic run(bit ex, int ch, int addr, int dw, int give, bit gap, bit sep);
        issue(ex, ch, addr, dw, give, gap, sep);
        wait_idle();
    endtask

    initial begin
        #1_900_000;
        mismatched++;
        $display("FAIL watchdog: actual=running expected=done");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "reset req_ready", req_ready, 1);
        check("R1", "reset ret_valid", ret_valid, 0);
        check("R1", "reset rd_start", rd_start, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "post-reset ret_discard", ret_discard, 0);

        cfg(3, 1, 20);
        cfg(5, 1, 0);
        cfg(6, 1, 700);
        cfg(2, 0, 40);

        // speculative, target gives 8 of 64 with disconnect on the 8th
        run(0, 0, 32'h100, 64, 8, 0, 0);
        check("R4", "spec bursts", n_start, 1);
        check("R8", "spec words kept with disconnect", n_take, 8);

        // speculative ends by count, no disconnect
        rmode = 2'd1;
        run(0, 1, 32'h2000, 5, 10, 1, 0);
        check("R8", "count-ended words", n_take, 5);
        check("R4", "count-ended bursts", n_start, 1);

        // exact: 20 dwords in bursts of 7 with gaps and a separate disconnect
        run(1, 3, 32'h3FFF_FFF8, 0, 7, 1, 1);
        check("R5", "exact bursts", n_start, 3);
        check("R5", "exact words", n_take, 20);

        // exact asked on a disabled channel
        run(1, 2, 32'h500, 16, 4, 0, 0);
        check("R6", "disabled channel bursts", n_start, 1);
        check("R6", "disabled channel len", first_len, 16);
        check("R6", "disabled channel words", n_take, 4);

        // speculative burst with no data
        run(0, 0, 32'h600, 12, 0, 0, 0);
        check("R9", "empty burst words", n_take, 0);
        check("R9", "empty burst idle", req_ready, 1);

        // length clamping
        run(1, 5, 32'h700, 9, 9, 0, 0);
        check("R3", "amount 0 served as 1", first_len, 1);
        check("R3", "amount 0 words", n_take, 1);
        rmode = 2'd0;
        run(1, 6, 32'h800, 0, 200, 0, 0);
        check("R3", "amount 700 served as 512", first_len, 512);
        check("R5", "512 split bursts", n_start, 3);
        check("R5", "512 words", n_take, 512);
        run(0, 6, 32'h900, 0, 4, 0, 0);
        check("R3", "spec 0 served as 1", first_len, 1);

        // table write in the same cycle as a request
        @(negedge clk);
        n_start = 0; n_take = 0; first_len = -1;
        t_give = 64; t_gap = 0; t_sep = 0;
        req_valid = 1; req_exact = 1; req_chan = 3'd3; req_addr = 30'h1000; req_dwords = '0;
        cfg_we = 1; cfg_chan = 3'd3; cfg_en = 1; cfg_amount = 10'd4;
        @(negedge clk);
        req_valid = 0; cfg_we = 0;
        wait_idle();
        check("R2", "same-cycle write unseen", first_len, 20);
        run(1, 3, 32'h1100, 0, 64, 0, 0);
        check("R2", "later request sees write", first_len, 4);

        // short timeout with one consumption part way
        rmode = 2'd3; man_rdy = 0; short_timeout = 1;
        issue(1, 3, 32'h1200, 0, 10, 0, 0);
        do @(negedge clk); while (!ret_valid);
        repeat (499) @(negedge clk);
        @(negedge clk); man_rdy = 1;
        @(negedge clk); man_rdy = 0;
        wait_idle();
        check("R11", "one word consumed", n_take, 1);
        check("R10", "short discard", n_disc, 1);

        // consumption on the expiring cycle wins
        issue(1, 3, 32'h1300, 0, 10, 0, 0);
        do @(negedge clk); while (!ret_valid);
        repeat (1022) @(negedge clk);
        @(negedge clk); man_rdy = 1;
        @(negedge clk); man_rdy = 0;
        check("R11", "no discard on taken cycle", n_disc, 0);
        check("R11", "word taken on expiring cycle", n_take, 1);
        wait_idle();
        check("R10", "discard after restart", n_disc, 1);

        // long timeout
        short_timeout = 0;
        run(0, 0, 32'h1400, 3, 3, 0, 0);
        check("R10", "long discard", n_disc, 1);
        check("R10", "long nothing taken", n_take, 0);

        rmode = 2'd0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule